// File: doc/BRIEF.md
# Adder Delay-Fault Logging Harness

This block drives an on-chip ripple-carry adder with a cyclic list of operand pairs, each chosen to sensitize one timing path whose slack is known in advance. It fetches the pairs from an external vector memory, presents them to the adder, samples the adder's sum and compares it with a sum it computes itself one pipeline stage earlier, with a full cycle of margin. Every disagreement is a fault.

A run has two windows of equal length. In the first (the baseline) the stress-enable output is low, and any vector that faults is marked unusable for the rest of the run. The harness then raises stress-enable in one cycle, which is time zero. During the second window, each fault on a vector that is still usable is written to a log FIFO. The entry holds the cycle count since time zero, the vector index and a flag that is set when the path has positive slack. Software-free readout happens through a first-word-fall-through pop port. A full log drops new faults, sets a sticky overflow flag and counts the losses. With the defaults a window is 10000 cycles, which is 200 µs at 50 MHz.

Top module: `adf_harness`

## Requirements
- R1: After reset, stress_en, done, vec_rd_en, log_valid and log_overflow are 0 and log_dropped is 0.
- R2: A start pulse seen while idle or done begins the baseline in the next cycle. From then on vec_rd_en is high and vec_addr steps 0,1,..,NUM_VEC-1,0,.. by one per cycle through both windows (2*WIN_CYCLES cycles). A start seen during either window is ignored.
- R3: stress_en is high for exactly the WIN_CYCLES cycles that follow the WIN_CYCLES baseline cycles. done is high from the cycle after the stress window until the next accepted start.
- R4: The vector memory answers a read one cycle after vec_addr. The operands of the vector addressed in cycle n drive add_a/add_b in cycle n+2. add_sum is sampled at the end of that cycle and compared with the 17-bit sum of the operands. Any difference is a fault for index n mod NUM_VEC.
- R5: A fault on a vector addressed during the baseline marks its index excluded, even when the comparison lands after stress_en has risen. Faults on excluded indices are never logged. Baseline faults are never logged.
- R6: A logged entry becomes visible on the log port in cycle n+4. It shows log_ts = (n+3) minus the first stress_en cycle, saturating at 16 bits, log_idx = n mod NUM_VEC, and log_slk_pos = the vec_slk_pos bit that the memory returned with the vector (1 = positive slack). Entries come out oldest first. log_valid is high while the log is not empty. log_pop with log_valid removes the head entry. log_pop on an empty log has no effect.
- R7: A fault that arrives while the log holds LOG_DEPTH entries is dropped, even if a pop happens in the same cycle. The drop sets log_overflow, which stays high until the next accepted start.
- R8: log_dropped counts dropped faults and saturates at its all-ones value.
- R9: An accepted start empties the log, clears log_overflow, log_dropped and all exclusions, and discards faults still in flight from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Harness clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| vec_rd_en | output | 1 | Vector memory read strobe |
| vec_addr | output | 8 | Vector memory address |
| vec_a | input | OPW | Operand A returned by the memory |
| vec_b | input | OPW | Operand B returned by the memory |
| vec_slk_pos | input | 1 | Slack metadata, 1 = positive slack |
| add_a | output | OPW | Operand A to the adder under test |
| add_b | output | OPW | Operand B to the adder under test |
| add_sum | input | OPW+1 | Sum from the adder under test |
| stress_en | output | 1 | Stress source enable, rising edge is time zero |
| done | output | 1 | Run finished |
| log_valid | output | 1 | Log holds at least one entry |
| log_pop | input | 1 | Remove head entry |
| log_ts | output | 16 | Head entry: cycles since time zero |
| log_idx | output | 8 | Head entry: vector index |
| log_slk_pos | output | 1 | Head entry: positive-slack flag |
| log_overflow | output | 1 | Sticky: a fault was dropped |
| log_dropped | output | DROP_W | Saturating count of dropped faults |

## Verification
The hardest case to reach is a vector issued in the last baseline cycles whose faulty sum is compared after stress_en has already risen. It must exclude its index and not appear in the log. The bench corrupts the sum of its own adder model in the exact cycle that vector's operands are presented, then corrupts the same index again later in the stress window. A second run floods the log with consecutive faults, with a pop landing on a full cycle, to reach the overflow and saturation of the drop counter. A third start shows that everything is cleared.

// File: rtl/adf_pkg.sv
package adf_pkg;
  localparam int TS_W  = 16;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BASE   = 2'd1,
    PH_STRESS = 2'd2,
    PH_DONE   = 2'd3
  } ph_e;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [IDX_W-1:0] idx;
    logic             slk_pos;
  } flt_rec_t;
endpackage

// File: rtl/adf_seq.sv
module adf_seq
  import adf_pkg::*;
#(
  parameter int NUM_VEC    = 64,
  parameter int WIN_CYCLES = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output ph_e              phase,
  output logic [IDX_W-1:0] addr,
  output logic [TS_W-1:0]  ts,
  output logic             clr
);
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
  localparam logic [IDX_W-1:0] VEC_LAST = IDX_W'(NUM_VEC - 1);

  ph_e              ph_q, ph_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [IDX_W-1:0] addr_q, addr_d;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic             running, win_end, win_en, ts_en;

  always_comb begin
    running = (ph_q == PH_BASE) || (ph_q == PH_STRESS);
    clr     = start && !running;
    win_end = running && (win_q == WIN_LAST);

    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (clr) ph_d = PH_BASE;
      PH_BASE:   if (win_end) ph_d = PH_STRESS;
      PH_STRESS: if (win_end) ph_d = PH_DONE;
      PH_DONE:   if (clr) ph_d = PH_BASE;
      default:   ph_d = PH_IDLE;
    endcase

    win_en = clr || running;
    if (clr || win_end) win_d = '0;
    else                win_d = win_q + 1'b1;

    if (clr || (addr_q == VEC_LAST)) addr_d = '0;
    else                             addr_d = addr_q + 1'b1;

    ts_en = clr || (((ph_q == PH_STRESS) || (ph_q == PH_DONE)) && (ts_q != '1));
    if (clr) ts_d = '0;
    else     ts_d = ts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      addr_q <= '0;
    end else if (win_en) begin
      win_q  <= win_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (ts_en) ts_q <= ts_d;
  end

  assign phase = ph_q;
  assign addr  = addr_q;
  assign ts    = ts_q;
endmodule

// File: rtl/adf_cmp.sv
module adf_cmp
  import adf_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             iss_vld,
  input  logic             iss_stress,
  input  logic [IDX_W-1:0] iss_idx,
  input  logic [OPW-1:0]   vec_a,
  input  logic [OPW-1:0]   vec_b,
  input  logic             vec_slk,
  input  logic [OPW:0]     add_sum,
  input  logic [TS_W-1:0]  ts,
  output logic [OPW-1:0]   op_a,
  output logic [OPW-1:0]   op_b,
  output logic             push,
  output flt_rec_t         rec
);
  localparam int EXCL_N = 1 << IDX_W;

  // stage 0: metadata waiting for memory data
  logic             s0_vld, s0_stress;
  logic [IDX_W-1:0] s0_idx;
  // stage 1: operands on the adder, reference computed
  logic             s1_vld, s1_stress, s1_slk;
  logic [IDX_W-1:0] s1_idx;
  logic [OPW-1:0]   s1_a, s1_b;
  logic [OPW:0]     s1_ref, ref_d;
  // stage 2: captured sum awaiting comparison
  logic             s2_vld, s2_stress, s2_slk;
  logic [IDX_W-1:0] s2_idx;
  logic [OPW:0]     s2_ref, s2_sum;

  logic             mismatch, excl_set, excl_hit;
  logic             excl_q [EXCL_N];

  always_comb begin
    ref_d    = {1'b0, vec_a} + {1'b0, vec_b};
    mismatch = s2_vld && (s2_sum != s2_ref);
    excl_set = mismatch && !s2_stress;
    excl_hit = excl_q[s2_idx];
    push     = mismatch && s2_stress && !excl_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_vld <= 1'b0;
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else if (clr) begin
      s0_vld <= 1'b0;
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s0_vld <= iss_vld;
      s1_vld <= s0_vld;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_stress <= 1'b0;
      s0_idx    <= '0;
    end else if (iss_vld) begin
      s0_stress <= iss_stress;
      s0_idx    <= iss_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_stress <= 1'b0;
      s1_idx    <= '0;
      s1_slk    <= 1'b0;
      s1_a      <= '0;
      s1_b      <= '0;
      s1_ref    <= '0;
    end else if (s0_vld) begin
      s1_stress <= s0_stress;
      s1_idx    <= s0_idx;
      s1_slk    <= vec_slk;
      s1_a      <= vec_a;
      s1_b      <= vec_b;
      s1_ref    <= ref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_stress <= 1'b0;
      s2_idx    <= '0;
      s2_slk    <= 1'b0;
      s2_ref    <= '0;
      s2_sum    <= '0;
    end else if (s1_vld) begin
      s2_stress <= s1_stress;
      s2_idx    <= s1_idx;
      s2_slk    <= s1_slk;
      s2_ref    <= s1_ref;
      s2_sum    <= add_sum;
    end
  end

  for (genvar g = 0; g < EXCL_N; g++) begin : g_excl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        excl_q[g] <= 1'b0;
      else if (clr)
        excl_q[g] <= 1'b0;
      else if (excl_set && (s2_idx == IDX_W'(g)))
        excl_q[g] <= 1'b1;
    end
  end

  assign op_a        = s1_a;
  assign op_b        = s1_b;
  assign rec.ts      = ts;
  assign rec.idx     = s2_idx;
  assign rec.slk_pos = s2_slk;
endmodule

// File: rtl/adf_log.sv
module adf_log
  import adf_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  flt_rec_t          rec_in,
  input  logic              pop,
  output logic              valid,
  output flt_rec_t          head,
  output logic              overflow,
  output logic [DROP_W-1:0] dropped
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;
  localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  flt_rec_t         mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, wr, rd, drop, ovf_q;
  logic [DROP_W-1:0] drop_q;

  always_comb begin
    full  = (cnt_q == CNT_FULL);
    valid = (cnt_q != '0);
    wr    = push && !full && !clr;
    rd    = pop && valid && !clr;
    drop  = push && full && !clr;

    wp_d = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
    rp_d = (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;

    cnt_d = cnt_q;
    if (wr && !rd)      cnt_d = cnt_q + 1'b1;
    else if (rd && !wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp_q] <= rec_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr) wp_q <= wp_d;
      if (rd) rp_q <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      drop_q <= '0;
    end else if (clr) begin
      ovf_q  <= 1'b0;
      drop_q <= '0;
    end else if (drop) begin
      ovf_q <= 1'b1;
      if (drop_q != '1) drop_q <= drop_q + 1'b1;
    end
  end

  assign head     = mem[rp_q];
  assign overflow = ovf_q;
  assign dropped  = drop_q;
endmodule

// File: rtl/adf_harness.sv
module adf_harness
  import adf_pkg::*;
#(
  parameter int OPW        = 16,
  parameter int NUM_VEC    = 64,
  parameter int WIN_CYCLES = 10000,
  parameter int LOG_DEPTH  = 256,
  parameter int DROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              vec_rd_en,
  output logic [IDX_W-1:0]  vec_addr,
  input  logic [OPW-1:0]    vec_a,
  input  logic [OPW-1:0]    vec_b,
  input  logic              vec_slk_pos,
  output logic [OPW-1:0]    add_a,
  output logic [OPW-1:0]    add_b,
  input  logic [OPW:0]      add_sum,
  output logic              stress_en,
  output logic              done,
  output logic              log_valid,
  input  logic              log_pop,
  output logic [TS_W-1:0]   log_ts,
  output logic [IDX_W-1:0]  log_idx,
  output logic              log_slk_pos,
  output logic              log_overflow,
  output logic [DROP_W-1:0] log_dropped
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  srst_n;
  ph_e                   phase;
  logic [TS_W-1:0]       ts;
  logic                  clr, issuing, push;
  flt_rec_t              rec, head;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_sync_q[RST_STAGES-1];

  adf_seq #(
    .NUM_VEC   (NUM_VEC),
    .WIN_CYCLES(WIN_CYCLES)
  ) u_seq (
    .clk  (clk),
    .rst_n(srst_n),
    .start(start),
    .phase(phase),
    .addr (vec_addr),
    .ts   (ts),
    .clr  (clr)
  );

  assign issuing   = (phase == PH_BASE) || (phase == PH_STRESS);
  assign vec_rd_en = issuing;
  assign stress_en = (phase == PH_STRESS);
  assign done      = (phase == PH_DONE);

  adf_cmp #(
    .OPW(OPW)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (srst_n),
    .clr       (clr),
    .iss_vld   (issuing),
    .iss_stress(stress_en),
    .iss_idx   (vec_addr),
    .vec_a     (vec_a),
    .vec_b     (vec_b),
    .vec_slk   (vec_slk_pos),
    .add_sum   (add_sum),
    .ts        (ts),
    .op_a      (add_a),
    .op_b      (add_b),
    .push      (push),
    .rec       (rec)
  );

  adf_log #(
    .DEPTH (LOG_DEPTH),
    .DROP_W(DROP_W)
  ) u_log (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (clr),
    .push    (push),
    .rec_in  (rec),
    .pop     (log_pop),
    .valid   (log_valid),
    .head    (head),
    .overflow(log_overflow),
    .dropped (log_dropped)
  );

  assign log_ts      = head.ts;
  assign log_idx     = head.idx;
  assign log_slk_pos = head.slk_pos;
endmodule

// File: rtl/adf_harness_chk.sv
module adf_harness_chk
  import adf_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int DROP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              vec_rd_en,
  input logic [IDX_W-1:0]  vec_addr,
  input logic              stress_en,
  input logic              done,
  input logic              log_overflow,
  input logic [DROP_W-1:0] log_dropped
);
  localparam logic [IDX_W-1:0] VEC_LAST = IDX_W'(NUM_VEC - 1);

  // R3: stress only while vectors are being fetched, never together with done
  p_stress_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stress_en |-> (vec_rd_en && !done));

  // R3: stress is entered straight from an active baseline
  p_stress_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stress_en) |-> $past(vec_rd_en));

  // R2: addresses advance by one and wrap at NUM_VEC
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_en && $past(vec_rd_en)) |->
      (($past(vec_addr) == VEC_LAST) ? (vec_addr == '0)
                                     : (vec_addr == $past(vec_addr) + 1'b1)));

  // R7: overflow flag is sticky until a start
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (log_overflow && !start) |=> log_overflow);

  // R8: dropped counter never goes down without a start
  p_drop_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (log_dropped >= $past(log_dropped)));

  // R8: any drop is also reported as overflow
  p_drop_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_dropped != '0) |-> log_overflow);
endmodule

bind adf_harness adf_harness_chk #(
  .NUM_VEC(NUM_VEC),
  .DROP_W (DROP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .vec_rd_en   (vec_rd_en),
  .vec_addr    (vec_addr),
  .stress_en   (stress_en),
  .done        (done),
  .log_overflow(log_overflow),
  .log_dropped (log_dropped)
);

// File: tb/adf_harness_tb_top.sv
module adf_harness_tb_top;
  localparam int OPW      = 16;
  localparam int NV       = 8;
  localparam int W        = 40;
  localparam int DEPTH    = 8;
  localparam int DROP_W   = 3;
  localparam int DROP_MAX = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              log_pop = 1'b0;
  logic              vec_rd_en, vec_slk_pos;
  logic [7:0]        vec_addr;
  logic [OPW-1:0]    vec_a, vec_b, add_a, add_b;
  logic [OPW:0]      add_sum;
  logic              stress_en, done, log_valid, log_slk_pos, log_overflow;
  logic [15:0]       log_ts;
  logic [7:0]        log_idx;
  logic [DROP_W-1:0] log_dropped;

  always #2 clk = ~clk;  // 250 MHz

  adf_harness #(
    .OPW(OPW), .NUM_VEC(NV), .WIN_CYCLES(W), .LOG_DEPTH(DEPTH), .DROP_W(DROP_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vec_rd_en(vec_rd_en), .vec_addr(vec_addr),
    .vec_a(vec_a), .vec_b(vec_b), .vec_slk_pos(vec_slk_pos),
    .add_a(add_a), .add_b(add_b), .add_sum(add_sum),
    .stress_en(stress_en), .done(done),
    .log_valid(log_valid), .log_pop(log_pop),
    .log_ts(log_ts), .log_idx(log_idx), .log_slk_pos(log_slk_pos),
    .log_overflow(log_overflow), .log_dropped(log_dropped)
  );

  // ---------------- vector memory and adder models ----------------
  function automatic logic [OPW-1:0] va(int k); return OPW'(k * 4951 + 61680); endfunction
  function automatic logic [OPW-1:0] vb(int k); return OPW'(65535 - k * 801); endfunction
  function automatic bit vs(int k); return (k % 3) != 0; endfunction

  always @(posedge clk) begin
    if (vec_rd_en) begin
      vec_a       <= va(int'(vec_addr));
      vec_b       <= vb(int'(vec_addr));
      vec_slk_pos <= vs(int'(vec_addr));
    end
  end

  bit inj_map [int];
  bit inj_now = 1'b0;
  assign add_sum = ({1'b0, add_a} + {1'b0, add_b}) ^ (inj_now ? 17'h00010 : 17'h00000);

  // ---------------- behavioural reference model ----------------
  int  cyc = 0;
  bit  run = 1'b0;
  bit  excl [NV];
  int  q_ts[$], q_idx[$], q_slk[$];
  bit  m_ovf = 1'b0;
  int  m_drop = 0;
  int  mc, mn, mi;
  bit  mfull;

  always @(posedge clk) begin
    mc    = cyc;
    mfull = (q_ts.size() >= DEPTH);
    if (log_pop && q_ts.size() > 0) begin
      void'(q_ts.pop_front()); void'(q_idx.pop_front()); void'(q_slk.pop_front());
    end
    if (run && (mc - 1) >= 2 && inj_map.exists(mc - 1)) begin
      mn = mc - 3;
      mi = mn % NV;
      if (mn < W) excl[mi] = 1'b1;
      else if (!excl[mi]) begin
        if (!mfull) begin
          q_ts.push_back(mc - W); q_idx.push_back(mi); q_slk.push_back(int'(vs(mi)));
        end else begin
          m_ovf = 1'b1;
          if (m_drop < DROP_MAX) m_drop++;
        end
      end
    end
    if (start && rst_n && (!run || mc >= 2 * W)) begin
      q_ts.delete(); q_idx.delete(); q_slk.delete();
      foreach (excl[k]) excl[k] = 1'b0;
      m_ovf = 1'b0; m_drop = 0;
      run     <= 1'b1;
      cyc     <= 0;
      inj_now <= inj_map.exists(0);
    end else begin
      cyc     <= mc + 1;
      inj_now <= run && inj_map.exists(mc + 1);
    end
  end

  // ---------------- checking ----------------
  int  n_chk = 0, n_bad = 0;
  bit  chk_on = 1'b0, finished = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cyc %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      bit exp_rd;
      exp_rd = run && cyc < 2 * W;
      chk(vec_rd_en == exp_rd, "R2", "vec_rd_en", int'(vec_rd_en), int'(exp_rd));
      if (exp_rd) chk(int'(vec_addr) == cyc % NV, "R2", "vec_addr", int'(vec_addr), cyc % NV);
      chk(stress_en == (run && cyc >= W && cyc < 2 * W), "R3", "stress_en",
          int'(stress_en), int'(run && cyc >= W && cyc < 2 * W));
      chk(done == (run && cyc >= 2 * W), "R3", "done", int'(done), int'(run && cyc >= 2 * W));
      chk(log_valid == (q_ts.size() > 0), "R6", "log_valid", int'(log_valid), int'(q_ts.size() > 0));
      if (q_ts.size() > 0) begin
        chk(int'(log_ts) == q_ts[0], "R6", "log_ts", int'(log_ts), q_ts[0]);
        chk(int'(log_idx) == q_idx[0], "R4", "log_idx", int'(log_idx), q_idx[0]);
        chk(int'(log_slk_pos) == q_slk[0], "R6", "log_slk_pos", int'(log_slk_pos), q_slk[0]);
      end
      chk(log_overflow == m_ovf, "R7", "log_overflow", int'(log_overflow), int'(m_ovf));
      chk(int'(log_dropped) == m_drop, "R8", "log_dropped", int'(log_dropped), m_drop);
    end
  end

  task automatic wait_cyc(int k);
    while (cyc != k) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pop_expect(int ts, int idx, int slk, string tag);
    chk(log_valid == 1'b1, tag, "log_valid before pop", int'(log_valid), 1);
    chk(int'(log_ts) == ts, tag, "popped ts", int'(log_ts), ts);
    chk(int'(log_idx) == idx, tag, "popped idx", int'(log_idx), idx);
    chk(int'(log_slk_pos) == slk, tag, "popped slack flag", int'(log_slk_pos), slk);
    log_pop = 1'b1; @(negedge clk); log_pop = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    int npop;
    repeat (4) @(negedge clk);
    // R1: outputs while reset is held and right after release
    chk(stress_en == 1'b0, "R1", "stress_en in reset", int'(stress_en), 0);
    chk(log_valid == 1'b0, "R1", "log_valid in reset", int'(log_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vec_rd_en == 1'b0, "R1", "vec_rd_en", int'(vec_rd_en), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(log_overflow == 1'b0, "R1", "log_overflow", int'(log_overflow), 0);
    chk(int'(log_dropped) == 0, "R1", "log_dropped", int'(log_dropped), 0);
    chk_on = 1'b1;

    // run 1: exclusion and timestamps (R5, R6)
    foreach (inj_map[k]) inj_map.delete(k);
    inj_map[5] = 1; inj_map[20] = 1; inj_map[40] = 1;  // baseline faults: idx 3, 2, 6
    inj_map[42] = 1; inj_map[45] = 1; inj_map[46] = 1; inj_map[48] = 1;
    inj_map[60] = 1; inj_map[61] = 1; inj_map[71] = 1; inj_map[81] = 1;
    pulse_start();
    log_pop = 1'b1; @(negedge clk); log_pop = 1'b0;  // pop on empty log, R6
    wait_cyc(10); pulse_start();                      // ignored mid-run, R2
    wait_cyc(50);
    pop_expect(3, 0, 0, "R6");
    wait_cyc(90);
    pop_expect(7, 4, 1, "R5");
    pop_expect(32, 5, 1, "R5");
    pop_expect(42, 7, 1, "R5");
    chk(log_valid == 1'b0, "R5", "log empty after run 1", int'(log_valid), 0);

    // run 2: overflow and saturation (R7, R8)
    foreach (inj_map[k]) inj_map.delete(k);
    for (int m = 42; m <= 60; m++) inj_map[m] = 1;
    pulse_start();
    wait_cyc(55); log_pop = 1'b1; @(negedge clk); log_pop = 1'b0;
    wait_cyc(70);
    chk(log_overflow == 1'b1, "R7", "overflow set", int'(log_overflow), 1);
    chk(int'(log_dropped) == DROP_MAX, "R8", "dropped saturated", int'(log_dropped), DROP_MAX);
    wait_cyc(90);
    npop = 0;
    while (log_valid && npop < 20) begin
      log_pop = 1'b1; @(negedge clk); log_pop = 1'b0; npop++;
    end
    chk(npop == DEPTH, "R7", "entries held", npop, DEPTH);
    chk(log_overflow == 1'b1, "R7", "overflow sticky after drain", int'(log_overflow), 1);

    // run 3: start clears (R9)
    foreach (inj_map[k]) inj_map.delete(k);
    inj_map[44] = 1;
    pulse_start();
    chk(log_overflow == 1'b0, "R9", "overflow cleared", int'(log_overflow), 0);
    chk(int'(log_dropped) == 0, "R9", "dropped cleared", int'(log_dropped), 0);
    wait_cyc(90);
    pop_expect(5, 2, 1, "R9");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule